// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management end of a serial PHY management bus. A client places a PHY address, a register address, sixteen bits of write data and a read/write choice on a request port. The block then produces one complete management frame on the MDC clock and the MDIO data line, and reports when the frame is over. For a read, it hands back the sixteen data bits or an error flag.

MDC is produced by dividing the system clock. The half-period is set by a parameter, so the default keeps MDC at 2.5 MHz from a 250 MHz system clock. The block owns the output-enable of the MDIO pad. It turns the pad off wherever the PHY is expected to drive the line, and in the idle bit after a write.

A read whose first sampled turnaround bit comes back high means no PHY answered. That read is reported as failed, and no data is returned.

Top module: `mdio_frame_master`

## Requirements
- R1: A request is taken when `req_valid` is high while `busy` is low, and `busy` is high from the next cycle until the frame ends. A `req_valid` pulse while `busy` is high starts no frame and changes nothing in the frame in flight.
- R2: While a frame runs, MDC spends exactly MDC_HALF system cycles low and then MDC_HALF cycles high, so two consecutive MDC rising edges are 2*MDC_HALF cycles apart. MDC is low whenever `busy` is low.
- R3: Every frame opens with 32 MDC periods in which MDIO is driven (`mdio_oe`=1) at one.
- R4: After the opening run of ones, a read drives 14 bits, most significant bit first: start `01`, opcode `10`, the 5-bit PHY address, then the 5-bit register address.
- R5: After the 14 header bits, a read releases MDIO (`mdio_oe`=0) for 18 MDC periods and samples one bit in each. When the first sampled bit is 0, `rd_err` is 0 and `rd_data` holds the last 16 sampled bits, with the first of them as bit 15. The frame has 64 MDC rising edges in total.
- R6: A read whose first sampled bit is 1 ends with `rd_err`=1 and `rd_data`=0.
- R7: After the opening run of ones, a write drives the 32-bit word {`01`, `01`, PHY address, register address, `10`, write data}, most significant bit first.
- R8: After the last write bit, the block keeps MDIO released for one more full MDC period (the 65th rising edge sees `mdio_oe`=0) before `done`. A write ends with `rd_err`=0.
- R9: `mdio_o` and `mdio_oe` change only while MDC is low, so each bit is set up before the MDC rising edge that transfers it. Each read sample is taken on the system cycle that raises MDC.
- R10: `done` is high for exactly one cycle at the end of each frame, and `busy` is already low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rd_data | output | 16 | Data of the last successful read, 0 after a failed read |
| rd_err | output | 1 | Last read found no responding PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench builds the block with MDC_HALF=2, giving a four-cycle MDC period. A full 64- or 65-edge frame then lasts only a few hundred cycles, and a run can cover back-to-back writes, successful and failed reads, and a request dropped while busy. The exact half-period check in R2 is measured against this small divisor. The default divisor of 50 changes only the length of each bit, not the bit sequence.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS  = 32;
    localparam int WR_BITS   = 32;
    localparam int RD_HDR    = 14;
    localparam int RD_SAMP   = 18;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int CNT_W     = $clog2(PRE_BITS + 1);

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PRE,
        SEQ_DRV,
        SEQ_SAMP,
        SEQ_TAIL
    } seq_st_e;

    function automatic logic [WR_BITS-1:0] pack_word(
        input logic              wr,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg,
        input logic [DATA_W-1:0] wd
    );
        if (wr)
            return {SOF_CODE, OP_WRITE, phy, rg, TA_DRIVE, wd};
        else
            return {SOF_CODE, OP_READ, phy, rg, {RD_SAMP{1'b0}}};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int LW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t q, d;
    logic wrap;

    assign wrap      = run && (q.cnt == CW'(HALF - 1));
    assign rise_tick = wrap && !q.mdc;
    assign fall_tick = wrap && q.mdc;
    assign mdc       = q.mdc;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // checker state: length of the current MDC level while running
    logic          mdc_seen_q;
    logic [LW-1:0] len_q;
    logic          toggled;

    assign toggled = (q.mdc != mdc_seen_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_seen_q <= 1'b0;
            len_q      <= '0;
        end else begin
            mdc_seen_q <= q.mdc;
            if (!run)         len_q <= '0;
            else if (toggled) len_q <= LW'(1);
            else              len_q <= len_q + 1'b1;
        end
    end

    p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (len_q <= LW'(HALF)));

    p_half_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (toggled && run) |-> (len_q == LW'(HALF)));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              run,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    typedef struct packed {
        seq_st_e            st;
        logic [WR_BITS-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic               wr;
        logic               ta_first;
        logic [DATA_W-1:0]  rx;
        logic               mo;
        logic               oe;
        logic               done;
        logic [DATA_W-1:0]  rdata;
        logic               rerr;
    } seq_t;

    seq_t q, d;

    assign run     = (q.st != SEQ_IDLE);
    assign mdio_o  = q.mo;
    assign mdio_oe = q.oe;
    assign done    = q.done;
    assign rd_data = q.rdata;
    assign rd_err  = q.rerr;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    d.st       = SEQ_PRE;
                    d.sh       = pack_word(req_write, req_phy, req_reg, req_wdata);
                    d.wr       = req_write;
                    d.left     = CNT_W'(PRE_BITS - 1);
                    d.mo       = 1'b1;
                    d.oe       = 1'b1;
                    d.rx       = '0;
                    d.ta_first = 1'b0;
                end
            end
            SEQ_PRE: begin
                if (fall_tick) begin
                    if (q.left == '0) begin
                        d.st   = SEQ_DRV;
                        d.left = q.wr ? CNT_W'(WR_BITS - 1) : CNT_W'(RD_HDR - 1);
                        d.mo   = q.sh[WR_BITS-1];
                        d.sh   = {q.sh[WR_BITS-2:0], 1'b0};
                    end else begin
                        d.left = q.left - 1'b1;
                    end
                end
            end
            SEQ_DRV: begin
                if (fall_tick) begin
                    if (q.left == '0) begin
                        d.oe = 1'b0;
                        d.mo = 1'b0;
                        if (q.wr) begin
                            d.st = SEQ_TAIL;
                        end else begin
                            d.st   = SEQ_SAMP;
                            d.left = CNT_W'(RD_SAMP - 1);
                        end
                    end else begin
                        d.left = q.left - 1'b1;
                        d.mo   = q.sh[WR_BITS-1];
                        d.sh   = {q.sh[WR_BITS-2:0], 1'b0};
                    end
                end
            end
            SEQ_SAMP: begin
                if (rise_tick) begin
                    if (q.left == CNT_W'(RD_SAMP - 1))
                        d.ta_first = mdio_i;
                    d.rx = {q.rx[DATA_W-2:0], mdio_i};
                end
                if (fall_tick) begin
                    if (q.left == '0) begin
                        d.st    = SEQ_IDLE;
                        d.done  = 1'b1;
                        d.rerr  = q.ta_first;
                        d.rdata = q.ta_first ? '0 : q.rx;
                    end else begin
                        d.left = q.left - 1'b1;
                    end
                end
            end
            SEQ_TAIL: begin
                if (fall_tick) begin
                    d.st   = SEQ_IDLE;
                    d.done = 1'b1;
                    d.rerr = 1'b0;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SEQ_IDLE;
        end else begin
            q <= d;
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && q.st == SEQ_IDLE) |=> (q.st == SEQ_PRE));

    p_hold_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(q.wr));

    p_pre_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_PRE) |-> (mdio_oe && mdio_o));

    p_samp_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_SAMP) |-> !mdio_oe);

    p_tail_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SEQ_TAIL) |-> !mdio_oe);

    p_err_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_err) |-> (rd_data == '0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run);

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic run, rise_tick, fall_tick;

    mdio_clk_div #(.HALF(MDC_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .run       (run),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .rd_data   (rd_data),
        .rd_err    (rd_err)
    );

    assign busy = run;

    p_setup_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

    p_idle_mdc_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

endmodule

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, rd_err, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    mdio_frame_master #(.MDC_HALF(HALF)) u_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model with a pull-up on the released line
    logic        phy_en = 1'b0;
    logic [17:0] phy_resp = '0;
    logic        phy_bit = 1'b1;
    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    typedef struct {
        bit        wr;
        bit [4:0]  phy;
        bit [4:0]  rg;
        bit [15:0] data;
        bit        err;
    } exp_t;
    exp_t sbq[$];

    int n_chk = 0, n_bad = 0, rise_n = 0, cyc = 0, dones = 0;
    bit o_s[0:79];
    bit oe_s[0:79];
    int rise_cyc[0:79];
    bit mdc_prev = 1'b0, last_done = 1'b0, finished = 1'b0;

    function automatic void chk(bit ok, string tag, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endfunction

    function automatic void check_frame();
        exp_t e;
        bit ok;
        logic [31:0] w, wexp;
        logic [13:0] h, hexp;
        dones++;
        chk(busy == 1'b0, "R10", "busy at done", busy, 0);
        if (sbq.size() == 0) begin
            chk(1'b0, "R1", "unexpected frame", 1, 0);
            rise_n = 0;
            return;
        end
        e = sbq.pop_front();
        ok = 1'b1;
        for (int i = 0; i < 32; i++) if (!(o_s[i] && oe_s[i])) ok = 1'b0;
        chk(ok, "R3", "preamble ones driven", ok, 1);
        ok = 1'b1;
        for (int i = 0; i + 1 < rise_n && i < 79; i++)
            if (rise_cyc[i+1] - rise_cyc[i] != 2*HALF) ok = 1'b0;
        chk(ok, "R2", "mdc rise spacing", ok, 1);
        if (e.wr) begin
            wexp = {2'b01, 2'b01, e.phy, e.rg, 2'b10, e.data};
            ok = 1'b1;
            for (int i = 0; i < 32; i++) begin
                w[31-i] = o_s[32+i];
                if (!oe_s[32+i]) ok = 1'b0;
            end
            chk(w == wexp, "R7", "write word", w, wexp);
            chk(ok, "R7", "write word driven", ok, 1);
            chk(rise_n == 65, "R8", "write rise count", rise_n, 65);
            chk(oe_s[64] == 1'b0, "R8", "tail released", oe_s[64], 0);
            chk(rd_err == 1'b0, "R8", "write rd_err", rd_err, 0);
        end else begin
            hexp = {2'b01, 2'b10, e.phy, e.rg};
            ok = 1'b1;
            for (int i = 0; i < 14; i++) begin
                h[13-i] = o_s[32+i];
                if (!oe_s[32+i]) ok = 1'b0;
            end
            chk(h == hexp, "R4", "read header", h, hexp);
            chk(ok, "R4", "header driven", ok, 1);
            ok = 1'b1;
            for (int i = 46; i < 64; i++) if (oe_s[i]) ok = 1'b0;
            chk(ok, "R5", "sample window released", ok, 1);
            chk(rise_n == 64, "R5", "read rise count", rise_n, 64);
            if (e.err) begin
                chk(rd_err == 1'b1, "R6", "no-PHY rd_err", rd_err, 1);
                chk(rd_data == 16'h0, "R6", "no-PHY rd_data", rd_data, 0);
            end else begin
                chk(rd_err == 1'b0, "R5", "rd_err", rd_err, 0);
                chk(rd_data == e.data, "R5", "rd_data", rd_data, e.data);
            end
        end
        rise_n = 0;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (last_done) chk(done == 1'b0, "R10", "done width", done, 0);
            last_done = done;
            if (mdc && !mdc_prev) begin
                if (rise_n < 80) begin
                    o_s[rise_n]      = mdio_o;
                    oe_s[rise_n]     = mdio_oe;
                    rise_cyc[rise_n] = cyc;
                end
                rise_n++;
            end
            if (!mdc && mdc_prev) begin
                if (rise_n >= 46 && rise_n < 64) phy_bit = phy_resp[63-rise_n];
                else                             phy_bit = 1'b1;
            end
            if (done) check_frame();
        end
        mdc_prev = mdc;
    end

    task automatic run_req(bit wr, bit [4:0] phy, bit [4:0] rg, bit [15:0] data, bit responder);
        exp_t e;
        e.wr = wr; e.phy = phy; e.rg = rg; e.data = data; e.err = !wr && !responder;
        @(negedge clk);
        while (busy) @(negedge clk);
        phy_en   = responder && !wr;
        phy_resp = {2'b00, data};
        sbq.push_back(e);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        int dn;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(mdc == 1'b0, "R2", "reset mdc", mdc, 0);
        chk(mdio_oe == 1'b0, "R5", "reset oe", mdio_oe, 0);
        chk(done == 1'b0, "R10", "reset done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mdc == 1'b0, "R2", "idle mdc", mdc, 0);

        run_req(1'b1, 5'h01, 5'h00, 16'h1234, 1'b0);
        run_req(1'b1, 5'h1F, 5'h1F, 16'hA5C3, 1'b0);
        run_req(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0);
        run_req(1'b0, 5'h02, 5'h01, 16'h796D, 1'b1);
        run_req(1'b0, 5'h15, 5'h0A, 16'h8001, 1'b1);
        run_req(1'b0, 5'h07, 5'h03, 16'h0000, 1'b0);
        run_req(1'b0, 5'h1E, 5'h11, 16'hFFFF, 1'b1);
        run_req(1'b1, 5'h0C, 5'h15, 16'h5AF0, 1'b0);

        // R1: a request made while busy must be dropped
        begin
            exp_t e;
            e.wr = 1'b1; e.phy = 5'h09; e.rg = 5'h06; e.data = 16'hC00F; e.err = 1'b0;
            sbq.push_back(e);
            phy_en = 1'b0;
            req_valid = 1'b1; req_write = 1'b1; req_phy = 5'h09; req_reg = 5'h06;
            req_wdata = 16'hC00F;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (60) @(negedge clk);
            dn = dones;
            req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h13; req_reg = 5'h02;
            req_wdata = 16'h0F0F;
            @(negedge clk);
            req_valid = 1'b0;
            while (busy) @(negedge clk);
            repeat (300) @(negedge clk);
            chk(dones == dn + 1, "R1", "frames after busy request", dones, dn + 1);
            chk(busy == 1'b0, "R1", "idle after busy request", busy, 0);
            chk(mdc == 1'b0, "R2", "mdc low after frames", mdc, 0);
            chk(sbq.size() == 0, "R1", "scoreboard drained", sbq.size(), 0);
        end
        summary();
    end

endmodule